// File: doc/BRIEF.md
# Linked-Descriptor Transfer Channel Sequencer

This block sequences one transfer channel whose work is described by descriptors held in memory. A start pulse makes it read the first descriptor through a request/acknowledge port. It then waits for a trigger from the selected source: software, an event line or a peripheral request. Once triggered, it issues one beat request per remaining beat. Each beat carries a source and a destination address. Each address either stays fixed or advances by a power-of-two step after every acknowledged beat.

When the beat count of a block reaches zero, the sequencer follows the descriptor's link address to fetch the next block. A link of zero ends the transaction. A link back to an earlier descriptor makes the chain loop, which gives circular buffering.

A suspend request, or a preemption from a higher-priority channel, makes the sequencer write its live descriptor to a dedicated write-back address. Resume, or the end of preemption, reads that copy back and continues from the same beat. Completion, error and suspend interrupt pulses can each be enabled. A completion event line can be set to pulse per beat, per block or per transaction.

Top module: `dma_chain_seq`

## Requirements
- R1: A `chanStart` pulse while idle raises `descReq` with `descWrite` low and `descAddr` = `firstDescAddr` in the next cycle. `descReq`, `descWrite` and `descAddr` hold until `descAck`. `chanStart` has no effect while the channel is active, and `chanActive` is high whenever the channel is not idle.
- R2: The descriptor is 61 bits, packed MSB first: valid(1), srcInc(1), dstInc(1), stepLog(2), beatCnt(8), srcAddr(16), dstAddr(16), nextAddr(16). An acknowledged read whose valid bit is 0 returns the channel to idle. It also gives a one-cycle `irqErr` pulse, if `irqEn[1]` is set, and no beat is issued.
- R3: A freshly loaded block waits for a trigger from the source chosen by `trigSel` (0 software, 1 event, 2 peripheral, 3 any). Triggers from the other sources are ignored.
- R4: While running with a nonzero beat count, `beatReq` is high. Each cycle with `beatReq` and `beatAck` both high consumes one beat.
- R5: After each consumed beat, `beatSrc` and `beatDst` each advance by 2^stepLog when their increment bit is 1, and stay unchanged when it is 0.
- R6: When the count reaches zero, `irqDone` pulses for one cycle if `irqEn[0]` is set. The channel then fetches from `nextAddr`, or goes idle if `nextAddr` is zero.
- R7: A link that points back to an earlier descriptor makes the chain repeat indefinitely.
- R8: `suspendReq`, while waiting or running, writes the live descriptor to `wbAddr` (`descWrite` high). After the acknowledge, the channel parks with no beats and `irqSusp` pulses if `irqEn[2]` is set.
- R9: `resumeReq` while suspended reads the descriptor back from `wbAddr`. A channel that was running continues at the saved addresses and count without a new trigger. A channel that was waiting waits for a trigger again.
- R10: `preemptReq` high while running writes back like R8, without `irqSusp`, and holds the channel parked. When `preemptReq` falls, the channel re-reads from `wbAddr` and continues.
- R11: `evtOut` pulses for one cycle per consumed beat (`evtSel`=0), per finished block (1) or per finished transaction (2). It never pulses when `evtSel`=3.
- R12: An interrupt whose enable bit is clear never pulses.
- R13: After reset, the channel is idle with all request, interrupt and event outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanStart | input | 1 | Start pulse |
| firstDescAddr | input | 16 | Address of the first descriptor |
| wbAddr | input | 16 | Write-back area address |
| trigSw | input | 1 | Software trigger |
| trigEvt | input | 1 | Event trigger |
| trigPeriph | input | 1 | Peripheral request trigger |
| trigSel | input | 2 | Trigger source select |
| suspendReq | input | 1 | Suspend pulse |
| resumeReq | input | 1 | Resume pulse |
| preemptReq | input | 1 | Preemption level |
| descReq | output | 1 | Descriptor access request |
| descWrite | output | 1 | 1 = write-back, 0 = fetch |
| descAddr | output | 16 | Descriptor access address |
| descWrData | output | 61 | Live descriptor for write-back |
| descAck | input | 1 | Descriptor access acknowledge |
| descRdData | input | 61 | Fetched descriptor |
| beatReq | output | 1 | Beat request |
| beatSrc | output | 16 | Beat source address |
| beatDst | output | 16 | Beat destination address |
| beatAck | input | 1 | Beat acknowledge |
| irqEn | input | 3 | Enables: [0] done, [1] error, [2] suspend |
| evtSel | input | 2 | Event granularity select |
| chanActive | output | 1 | Channel not idle |
| irqDone | output | 1 | Block complete pulse |
| irqErr | output | 1 | Invalid descriptor pulse |
| irqSusp | output | 1 | Suspended pulse |
| evtOut | output | 1 | Completion event pulse |

## Verification
The request outputs (`descReq`, `descAddr`, `beatReq`) depend on state and on the same-cycle suspend and preempt inputs. They are due in the cycle the stimulus is applied. Addresses and counts take effect one clock after an acknowledge. Interrupt and event pulses are registered and appear exactly one clock after the acknowledge or the zero-count cycle that causes them.

The bench changes inputs just after the rising edge and compares every output against its behavioural model at mid-low phase, before that edge's effects can be missed. Descriptor and beat acknowledges are generated from the model's own expectation with varied latency.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  parameter int ADDR_W = 16;
  parameter int CNT_W  = 8;
  parameter int STEP_W = 2;

  typedef struct packed {
    logic              valid;
    logic              srcInc;
    logic              dstInc;
    logic [STEP_W-1:0] stepLog;
    logic [CNT_W-1:0]  beatCnt;
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
    logic [ADDR_W-1:0] nextAddr;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_RUN, ST_WB, ST_SUSP, ST_PARK
  } chan_state_t;

  typedef enum logic [1:0] {FA_FIRST, FA_NEXT, FA_WB} fa_sel_t;

  typedef struct packed {
    logic    ldDesc;
    logic    stepBeat;
    logic    ldFetch;
    fa_sel_t faSel;
  } dp_strobe_t;

  localparam logic [1:0] TRG_SW = 2'd0, TRG_EVT = 2'd1, TRG_PER = 2'd2;
  localparam logic [1:0] EVT_BEAT = 2'd0, EVT_BLOCK = 2'd1, EVT_TRANS = 2'd2;
endpackage

// File: rtl/dma_chain_dp.sv
module dma_chain_dp
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  desc_t             rdDesc,
  input  logic [ADDR_W-1:0] firstDescAddr,
  input  logic [ADDR_W-1:0] wbAddr,
  output desc_t             live,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              cntZero,
  output logic              nextZero
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] stepAmt;
  assign stepAmt  = ONE << live.stepLog;
  assign cntZero  = (live.beatCnt == '0);
  assign nextZero = (live.nextAddr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      live <= '0;
    end else if (stb.ldDesc) begin
      live <= rdDesc;
    end else if (stb.stepBeat) begin
      live.beatCnt <= live.beatCnt - 1'b1;
      if (live.srcInc) live.srcAddr <= live.srcAddr + stepAmt;
      if (live.dstInc) live.dstAddr <= live.dstAddr + stepAmt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
    end else if (stb.ldFetch) begin
      case (stb.faSel)
        FA_FIRST: fetchAddr <= firstDescAddr;
        FA_NEXT:  fetchAddr <= live.nextAddr;
        default:  fetchAddr <= wbAddr;
      endcase
    end
  end

  // R4: each consumed beat lowers the count by exactly one
  p_count_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepBeat |=> live.beatCnt == $past(live.beatCnt) - 1'b1);

  // R5: a static source address does not move on a beat
  p_src_static_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepBeat && !live.srcInc) |=> $stable(live.srcAddr));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanStart,
  input  logic       trigSw,
  input  logic       trigEvt,
  input  logic       trigPeriph,
  input  logic [1:0] trigSel,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       preemptReq,
  input  logic       descAck,
  input  logic       beatAck,
  input  logic       rdValid,
  input  logic       cntZero,
  input  logic       nextZero,
  input  logic [2:0] irqEn,
  input  logic [1:0] evtSel,
  output dp_strobe_t stb,
  output logic       descReq,
  output logic       descWrite,
  output logic       beatReq,
  output logic       chanActive,
  output logic       irqDone,
  output logic       irqErr,
  output logic       irqSusp,
  output logic       evtOut
);
  chan_state_t st, stNext;
  logic resumeFlag, wasRun, suspCause;
  logic trigHit, running, blockDone, errHit, suspHit, evtHit;

  always_comb begin
    case (trigSel)
      TRG_SW:  trigHit = trigSw;
      TRG_EVT: trigHit = trigEvt;
      TRG_PER: trigHit = trigPeriph;
      default: trigHit = trigSw | trigEvt | trigPeriph;
    endcase
  end

  assign running    = (st == ST_RUN) && !suspendReq && !preemptReq;
  assign beatReq    = running && !cntZero;
  assign blockDone  = running && cntZero;
  assign descReq    = (st == ST_FETCH) || (st == ST_WB);
  assign descWrite  = (st == ST_WB);
  assign chanActive = (st != ST_IDLE);
  assign errHit     = (st == ST_FETCH) && descAck && !rdValid;
  assign suspHit    = (st == ST_WB) && descAck && suspCause;

  always_comb begin
    case (evtSel)
      EVT_BEAT:  evtHit = stb.stepBeat;
      EVT_BLOCK: evtHit = blockDone;
      EVT_TRANS: evtHit = blockDone && nextZero;
      default:   evtHit = 1'b0;
    endcase
  end

  always_comb begin
    stNext       = st;
    stb          = '0;
    stb.faSel    = FA_FIRST;
    stb.stepBeat = beatReq && beatAck;
    stb.ldDesc   = (st == ST_FETCH) && descAck;
    case (st)
      ST_IDLE: if (chanStart) begin
        stb.ldFetch = 1'b1;
        stNext      = ST_FETCH;
      end
      ST_FETCH: if (descAck) begin
        if (!rdValid)                  stNext = ST_IDLE;
        else if (resumeFlag && wasRun) stNext = ST_RUN;
        else                           stNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (suspendReq)   stNext = ST_WB;
        else if (trigHit) stNext = ST_RUN;
      end
      ST_RUN: begin
        if (suspendReq || preemptReq) begin
          stNext = ST_WB;
        end else if (cntZero) begin
          if (nextZero) begin
            stNext = ST_IDLE;
          end else begin
            stb.ldFetch = 1'b1;
            stb.faSel   = FA_NEXT;
            stNext      = ST_FETCH;
          end
        end
      end
      ST_WB: if (descAck) stNext = suspCause ? ST_SUSP : ST_PARK;
      ST_SUSP: if (resumeReq) begin
        stb.ldFetch = 1'b1;
        stb.faSel   = FA_WB;
        stNext      = ST_FETCH;
      end
      ST_PARK: if (!preemptReq) begin
        stb.ldFetch = 1'b1;
        stb.faSel   = FA_WB;
        stNext      = ST_FETCH;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      resumeFlag <= 1'b0;
      wasRun     <= 1'b0;
      suspCause  <= 1'b0;
      irqDone    <= 1'b0;
      irqErr     <= 1'b0;
      irqSusp    <= 1'b0;
      evtOut     <= 1'b0;
    end else begin
      st      <= stNext;
      irqDone <= blockDone & irqEn[0];
      irqErr  <= errHit & irqEn[1];
      irqSusp <= suspHit & irqEn[2];
      evtOut  <= evtHit;
      if (stb.ldFetch) resumeFlag <= (stb.faSel == FA_WB);
      if (st == ST_WAIT && suspendReq) begin
        suspCause <= 1'b1;
        wasRun    <= 1'b0;
      end else if (st == ST_RUN && (suspendReq || preemptReq)) begin
        suspCause <= suspendReq;
        wasRun    <= 1'b1;
      end
    end
  end

  // R2: an error pulse is only seen once the channel is back to idle
  p_err_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |-> st == ST_IDLE);

  // R8: a suspend pulse coincides with the parked suspended state
  p_susp_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqSusp |-> st == ST_SUSP);

  // R1: an unanswered descriptor request keeps its direction
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (descReq && !descAck) |=> descReq && $stable(descWrite));

  // R6: a block-done pulse lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |=> !irqDone);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanStart,
  input  logic [ADDR_W-1:0] firstDescAddr,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic              trigSw,
  input  logic              trigEvt,
  input  logic              trigPeriph,
  input  logic [1:0]        trigSel,
  input  logic              suspendReq,
  input  logic              resumeReq,
  input  logic              preemptReq,
  output logic              descReq,
  output logic              descWrite,
  output logic [ADDR_W-1:0] descAddr,
  output logic [DESC_W-1:0] descWrData,
  input  logic              descAck,
  input  logic [DESC_W-1:0] descRdData,
  output logic              beatReq,
  output logic [ADDR_W-1:0] beatSrc,
  output logic [ADDR_W-1:0] beatDst,
  input  logic              beatAck,
  input  logic [2:0]        irqEn,
  input  logic [1:0]        evtSel,
  output logic              chanActive,
  output logic              irqDone,
  output logic              irqErr,
  output logic              irqSusp,
  output logic              evtOut
);
  dp_strobe_t        stb;
  desc_t             live, rdDesc;
  logic [ADDR_W-1:0] fetchAddr;
  logic              cntZero, nextZero;

  assign rdDesc     = desc_t'(descRdData);
  assign descWrData = live;
  assign descAddr   = descWrite ? wbAddr : fetchAddr;
  assign beatSrc    = live.srcAddr;
  assign beatDst    = live.dstAddr;

  dma_chain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanStart(chanStart),
    .trigSw(trigSw), .trigEvt(trigEvt), .trigPeriph(trigPeriph), .trigSel(trigSel),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .preemptReq(preemptReq),
    .descAck(descAck), .beatAck(beatAck), .rdValid(rdDesc.valid),
    .cntZero(cntZero), .nextZero(nextZero), .irqEn(irqEn), .evtSel(evtSel),
    .stb(stb), .descReq(descReq), .descWrite(descWrite), .beatReq(beatReq),
    .chanActive(chanActive), .irqDone(irqDone), .irqErr(irqErr),
    .irqSusp(irqSusp), .evtOut(evtOut)
  );

  dma_chain_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdDesc(rdDesc),
    .firstDescAddr(firstDescAddr), .wbAddr(wbAddr), .live(live),
    .fetchAddr(fetchAddr), .cntZero(cntZero), .nextZero(nextZero)
  );
endmodule

// File: tb/dma_chain_seq_test.sv
module dma_chain_seq_test;
  import dma_chain_pkg::*;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 100000;

  logic clk = 1'b0, rstN = 1'b0;
  logic chanStart = 0, trigSw = 0, trigEvt = 0, trigPeriph = 0;
  logic [1:0] trigSel = 0, evtSel = 0;
  logic suspendReq = 0, resumeReq = 0, preemptReq = 0;
  logic [15:0] firstDescAddr = 0, wbAddr = 16'h0F00;
  logic descReq, descWrite, descAck = 0, beatReq, beatAck = 0;
  logic [15:0] descAddr, beatSrc, beatDst;
  logic [DESC_W-1:0] descWrData, descRdData = '0;
  logic [2:0] irqEn = 3'b111;
  logic chanActive, irqDone, irqErr, irqSusp, evtOut;

  always #(CLK_PER/2) clk = ~clk;

  dma_chain_seq uut (.*);

  // behavioural reference
  desc_t mem [logic [15:0]];
  int ph = 0;           // 0 idle 1 fetch 2 wait 3 run 4 wb 5 susp 6 park
  logic [15:0] mFetch = 0;
  desc_t mLive = '0, rdD = '0;
  bit mResume = 0, mWasRun = 0, mSuspC = 0;
  bit mDone = 0, mErr = 0, mSusp = 0, mEvt = 0;
  bit eReq, eWr, eBeat;
  logic [15:0] eAddr;
  int reqAge = 0, ackPat = 0, cyc = 0;
  int nDone = 0, nErr = 0, nSusp = 0, f500 = 0;
  int total = 0, bad = 0;

  function automatic desc_t mk(bit v, bit si, bit di, int sl, int cnt,
                               int src, int dst, int nxt);
    desc_t d;
    d.valid = v; d.srcInc = si; d.dstInc = di; d.stepLog = 2'(sl);
    d.beatCnt = 8'(cnt); d.srcAddr = 16'(src); d.dstAddr = 16'(dst);
    d.nextAddr = 16'(nxt);
    return d;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit trigOk();
    case (trigSel)
      2'd0: return trigSw;
      2'd1: return trigEvt;
      2'd2: return trigPeriph;
      default: return trigSw | trigEvt | trigPeriph;
    endcase
  endfunction

  task automatic modelStep();
    logic [15:0] inc;
    mDone = 0; mErr = 0; mSusp = 0; mEvt = 0;
    if (!rstN) begin ph = 0; return; end
    case (ph)
      0: if (chanStart) begin mFetch = firstDescAddr; mResume = 0; ph = 1; end
      1: if (descAck) begin
        mLive = rdD;
        if (mFetch == 16'h0500) f500++;
        if (!rdD.valid) begin ph = 0; mErr = irqEn[1]; if (irqEn[1]) nErr++; end
        else ph = (mResume && mWasRun) ? 3 : 2;
      end
      2: if (suspendReq) begin ph = 4; mSuspC = 1; mWasRun = 0; end
         else if (trigOk()) ph = 3;
      3: if (suspendReq || preemptReq) begin
           ph = 4; mSuspC = suspendReq; mWasRun = 1;
         end else if (mLive.beatCnt == 0) begin
           mDone = irqEn[0]; if (irqEn[0]) nDone++;
           mEvt = (evtSel == 1) || (evtSel == 2 && mLive.nextAddr == 0);
           if (mLive.nextAddr == 0) ph = 0;
           else begin mFetch = mLive.nextAddr; mResume = 0; ph = 1; end
         end else if (beatAck) begin
           inc = 16'd1 << mLive.stepLog;
           mLive.beatCnt = mLive.beatCnt - 1;
           if (mLive.srcInc) mLive.srcAddr = mLive.srcAddr + inc;
           if (mLive.dstInc) mLive.dstAddr = mLive.dstAddr + inc;
           mEvt = (evtSel == 0);
         end
      4: if (descAck) begin
        mem[wbAddr] = mLive; mResume = 1;
        if (mSuspC) begin ph = 5; mSusp = irqEn[2]; if (irqEn[2]) nSusp++; end
        else ph = 6;
      end
      5: if (resumeReq) begin mFetch = wbAddr; ph = 1; end
      6: if (!preemptReq) begin mFetch = wbAddr; ph = 1; end
      default: ph = 0;
    endcase
  endtask

  task automatic cycle();
    @(negedge clk);
    eReq  = (ph == 1 || ph == 4);
    eWr   = (ph == 4);
    eAddr = eWr ? wbAddr : mFetch;
    eBeat = (ph == 3) && mLive.beatCnt != 0 && !suspendReq && !preemptReq;
    descAck = eReq && reqAge >= 1;
    rdD = (ph == 1 && mem.exists(mFetch)) ? mem[mFetch] : '0;
    descRdData = rdD;
    beatAck = eBeat && (ackPat % 3 != 1);
    ackPat++;
    #1;
    chk(descReq == eReq, "R1", "descReq", 64'(descReq), 64'(eReq));
    chk(chanActive == (ph != 0), "R1", "chanActive", 64'(chanActive), 64'(ph != 0));
    if (eReq) begin
      chk(descAddr == eAddr, "R1", "descAddr", 64'(descAddr), 64'(eAddr));
      chk(descWrite == eWr, "R8", "descWrite", 64'(descWrite), 64'(eWr));
    end
    if (eWr) chk(descWrData == mLive, "R8", "descWrData", 64'(descWrData), 64'(mLive));
    chk(beatReq == eBeat, "R4", "beatReq", 64'(beatReq), 64'(eBeat));
    if (eBeat) begin
      chk(beatSrc == mLive.srcAddr, "R5", "beatSrc", 64'(beatSrc), 64'(mLive.srcAddr));
      chk(beatDst == mLive.dstAddr, "R5", "beatDst", 64'(beatDst), 64'(mLive.dstAddr));
    end
    chk(irqDone == mDone, "R6", "irqDone", 64'(irqDone), 64'(mDone));
    chk(irqErr == mErr, "R2", "irqErr", 64'(irqErr), 64'(mErr));
    chk(irqSusp == mSusp, "R8", "irqSusp", 64'(irqSusp), 64'(mSusp));
    chk(evtOut == mEvt, "R11", "evtOut", 64'(evtOut), 64'(mEvt));
    @(posedge clk);
    if (eReq && !descAck) reqAge++; else reqAge = 0;
    modelStep();
    #1;
    cyc++;
    if (cyc > WDOG) begin
      chk(0, "watchdog", "cycles", 64'(cyc), 64'(WDOG));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic waitPh(int p);
    int n = 0;
    while (ph != p && n < 3000) begin cycle(); n++; end
    if (ph != p) chk(0, "watchdog", "phase", 64'(ph), 64'(p));
  endtask

  initial begin
    logic [15:0] savedSrc;
    int d0, s0;
    mem[16'h0100] = mk(1, 1, 0, 0, 3, 'h1000, 'h2000, 'h0110);
    mem[16'h0110] = mk(1, 0, 1, 2, 2, 'h3000, 'h4000, 'h0000);
    mem[16'h0200] = mk(0, 1, 1, 1, 4, 'h1111, 'h2222, 'h0000);
    mem[16'h0300] = mk(1, 1, 1, 1, 6, 'h5000, 'h6000, 'h0000);
    mem[16'h0400] = mk(1, 1, 0, 3, 5, 'h7000, 'h7800, 'h0000);
    mem[16'h0500] = mk(1, 1, 1, 0, 2, 'h8000, 'h9000, 'h0510);
    mem[16'h0510] = mk(1, 0, 0, 0, 1, 'hA000, 'hB000, 'h0500);
    run(3);
    rstN = 1'b1;
    run(2);
    // R13 reset state
    chk(!chanActive && !descReq && !beatReq && !irqDone && !irqErr && !irqSusp && !evtOut,
        "R13", "idle outputs", 64'({chanActive, descReq, beatReq, evtOut}), 64'(0));

    // chain of two blocks, software trigger, per-beat events
    firstDescAddr = 16'h0100; chanStart = 1; cycle(); chanStart = 0;
    waitPh(2);
    trigEvt = 1; cycle(); trigEvt = 0;
    run(3);
    chk(!beatReq && ph == 2, "R3", "wrong-source trigger ignored", 64'(beatReq), 64'(0));
    trigSw = 1; cycle(); trigSw = 0;
    run(1);
    chanStart = 1; cycle(); chanStart = 0;   // R1: ignored while active
    waitPh(2);
    trigSw = 1; cycle(); trigSw = 0;
    waitPh(0);
    run(2);
    chk(!chanActive && nDone == 2, "R6", "two blocks then idle", 64'(nDone), 64'(2));

    // invalid descriptor
    firstDescAddr = 16'h0200; chanStart = 1; cycle(); chanStart = 0;
    waitPh(0);
    run(2);
    chk(nErr == 1 && !chanActive, "R2", "error count", 64'(nErr), 64'(1));

    // suspend and resume while running, peripheral trigger, block events
    trigSel = 2'd2; evtSel = 2'd1;
    firstDescAddr = 16'h0300; chanStart = 1; cycle(); chanStart = 0;
    waitPh(2);
    trigPeriph = 1; cycle(); trigPeriph = 0;
    run(4);
    suspendReq = 1; cycle(); suspendReq = 0;
    waitPh(5);
    run(4);
    chk(nSusp == 1 && !beatReq, "R8", "suspended no beats", 64'(nSusp), 64'(1));
    savedSrc = mem[wbAddr].srcAddr;
    resumeReq = 1; cycle(); resumeReq = 0;
    waitPh(3);
    chk(beatSrc == savedSrc, "R9", "resume source", 64'(beatSrc), 64'(savedSrc));
    waitPh(0);

    // preemption with interrupts masked, transaction events
    irqEn = 3'b000; evtSel = 2'd2; trigSel = 2'd1;
    d0 = nDone; s0 = nSusp;
    firstDescAddr = 16'h0400; chanStart = 1; cycle(); chanStart = 0;
    waitPh(2);
    trigEvt = 1; cycle(); trigEvt = 0;
    run(3);
    preemptReq = 1;
    run(8);
    chk(ph == 6 && !beatReq && !descReq, "R10", "parked while preempted", 64'(beatReq), 64'(0));
    chk(nSusp == s0, "R10", "no suspend irq", 64'(nSusp), 64'(s0));
    preemptReq = 0;
    waitPh(0);
    chk(nDone == d0, "R12", "masked done irq", 64'(nDone), 64'(d0));

    // circular chain, any trigger
    irqEn = 3'b111; evtSel = 2'd0; trigSel = 2'd3;
    firstDescAddr = 16'h0500; chanStart = 1; cycle(); chanStart = 0;
    for (int k = 0; k < 4; k++) begin
      waitPh(2);
      if (k % 2 == 0) trigEvt = 1; else trigPeriph = 1;
      cycle(); trigEvt = 0; trigPeriph = 0;
    end
    waitPh(2);
    chk(f500 >= 3 && chanActive, "R7", "circular refetch", 64'(f500), 64'(3));
    suspendReq = 1; cycle(); suspendReq = 0;
    waitPh(5);
    resumeReq = 1; cycle(); resumeReq = 0;
    waitPh(2);
    chk(!beatReq, "R9", "waiting channel needs trigger", 64'(beatReq), 64'(0));
    evtSel = 2'd3;
    trigSw = 1; cycle(); trigSw = 0;
    run(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule